// File: doc/BRIEF.md
# Interrupt Acceptance and Priority Arbiter

This block sits between the incoming interrupt-message path and a processor core. Each message that reaches it carries an 8-bit vector, a 3-bit delivery mode and a trigger flag. Ordinary requests (fixed and lowest-priority modes) are queued, one bit per vector, in a request vector. The block also keeps a trigger-mode vector and an in-service vector. The four special kinds (system-management, non-maskable, init and external-controller) are not queued. Each one is latched as a single pending flag together with its vector.

From this state the block drives one pending line toward the core. The special unmaskable kinds always raise it. The external kind and queued requests raise it only while the core's interrupt-enable input is high. A queued request must also beat both the highest in-service vector and the task-priority class.

When the core strobes the acknowledge input, the block names the source it serves and that source's vector in the same cycle. On the following clock edge it updates its state for that source.

Top module: `irq_accept_arb`

## Requirements
- R1: After reset no source is pending. The request, trigger and in-service vectors are empty, `int_pending` is low, and an acknowledge returns kind 0 with vector 0.
- R2: A message with mode 0 (fixed) or mode 1 (lowest priority) sets the request bit of its vector. If that bit was clear, the trigger bit of the vector takes `msg_level` (1 = level, 0 = edge). A fixed acknowledge reports that trigger bit on `ack_level`.
- R3: A mode 0 or 1 message whose vector's request bit is already set changes neither the request bit nor the trigger bit.
- R4: A message with mode 2 (SMI), 4 (NMI) or 5 (INIT) sets that kind's pending flag and stores its vector, but only when the flag is clear. A repeat while the flag is set is dropped, and the first vector is kept.
- R5: A mode 7 (external) message follows the same rule as R4 with its own flag and vector. Modes 3 and 6 are reserved and change nothing.
- R6: `int_pending` is high whenever an SMI, NMI or INIT flag is set, whatever the value of `int_enable`.
- R7: With `int_enable` high, `int_pending` is also high when the external flag is set. It is also high when the highest pending request vector both exceeds the highest in-service vector ("none in service" ranks below every vector) and has bits [7:4] greater than `task_prio[7:4]`. With `int_enable` low, only the R6 sources count.
- R8: An acknowledge while `int_pending` is high serves exactly one source in this order: SMI, NMI, INIT, external, then the highest fixed request. In the same cycle it drives `ack_kind` (1 SMI, 2 NMI, 3 INIT, 4 external, 5 fixed) and `ack_vector`. Only the served source's flag is cleared.
- R9: A fixed acknowledge sets the in-service bit of the vector, makes that vector the highest in service and clears its request bit. The next highest request then becomes the candidate.
- R10: An acknowledge while `int_pending` is low returns kind 0 and vector 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | An interrupt message is presented this cycle |
| msg_vector | input | 8 | Vector of the message |
| msg_mode | input | 3 | Delivery mode of the message |
| msg_level | input | 1 | Trigger of the message, 1 = level |
| int_enable | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task priority; bits [7:4] form the class |
| ack | input | 1 | Core acknowledge strobe |
| int_pending | output | 1 | An interrupt is offered to the core |
| ack_kind | output | 3 | Kind of source served, valid with `ack` |
| ack_vector | output | 8 | Vector of the source served |
| ack_level | output | 1 | Trigger bit of a served fixed vector |

## Verification
The assertions assume that `ack` is held for a single cycle per acknowledgement. They also assume that `msg_valid` comes with a defined mode and vector, and that inputs change only between clock edges. The bench drives every input on the falling edge and pulses `ack` for exactly one cycle. It never presents a message and an acknowledge in the same cycle, so each step has a single cause, and the same-cycle properties hold under these conditions.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXTINT = 3'd7
  } dmode_e;

  typedef enum logic [2:0] {
    ACK_NONE  = 3'd0,
    ACK_SMI   = 3'd1,
    ACK_NMI   = 3'd2,
    ACK_INIT  = 3'd3,
    ACK_EXT   = 3'd4,
    ACK_FIXED = 3'd5
  } ack_kind_e;

  // special-source slots, lowest index wins
  localparam int SRC_SMI  = 0;
  localparam int SRC_NMI  = 1;
  localparam int SRC_INIT = 2;
  localparam int SRC_EXT  = 3;
  localparam int NUM_SRC  = 4;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int WIDTH = 256,
  parameter int GROUP = 16
) (
  input  logic [WIDTH-1:0]         req,
  output logic                     any,
  output logic [$clog2(WIDTH)-1:0] idx
);
  localparam int NGRP = WIDTH / GROUP;
  localparam int GW   = $clog2(GROUP);
  localparam int SW   = $clog2(NGRP);

  logic [NGRP-1:0]         grp_any;
  logic [NGRP-1:0][GW-1:0] loc_pos;
  logic [SW-1:0]           sel;

  // first level: highest set bit inside each group
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GW-1:0] lpos;
    always_comb begin
      lpos = '0;
      for (int j = 0; j < GROUP; j++) begin
        if (req[g*GROUP + j]) lpos = GW'(j);
      end
    end
    assign loc_pos[g] = lpos;
    assign grp_any[g] = |req[g*GROUP +: GROUP];
  end

  // second level: highest non-empty group
  always_comb begin
    sel = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) sel = SW'(g);
    end
  end

  assign any = |grp_any;
  assign idx = {sel, loc_pos[sel]};

endmodule

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
  parameter int NUM_VEC = 256,
  localparam int VW     = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fix_valid,
  input  logic [VW-1:0]      fix_vector,
  input  logic               fix_level,
  input  logic               serve,
  input  logic [VW-1:0]      serve_vec,
  output logic [NUM_VEC-1:0] irr_q,
  output logic [NUM_VEC-1:0] tmr_q,
  output logic [NUM_VEC-1:0] isr_q,
  output logic               isr_any_q,
  output logic [VW-1:0]      isr_top_q
);
  logic [NUM_VEC-1:0] irr_d, tmr_d, isr_d;
  logic               vec_en;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
    logic set_hit, srv_hit;
    assign set_hit  = fix_valid && (fix_vector == VW'(i));
    assign srv_hit  = serve && (serve_vec == VW'(i));
    assign irr_d[i] = srv_hit ? 1'b0 : (irr_q[i] | set_hit);
    assign tmr_d[i] = (set_hit && !irr_q[i]) ? fix_level : tmr_q[i];
    assign isr_d[i] = isr_q[i] | srv_hit;
  end

  assign vec_en = fix_valid | serve;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      tmr_q <= '0;
      isr_q <= '0;
    end else if (vec_en) begin
      irr_q <= irr_d;
      tmr_q <= tmr_d;
      isr_q <= isr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_any_q <= 1'b0;
      isr_top_q <= '0;
    end else if (serve) begin
      isr_any_q <= 1'b1;
      isr_top_q <= serve_vec;
    end
  end

endmodule

// File: rtl/irq_special_flags.sv
module irq_special_flags
  import irq_arb_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         set_req,
  input  logic [VW-1:0]              msg_vector,
  input  logic [NUM_SRC-1:0]         clr,
  output logic [NUM_SRC-1:0]         pend_q,
  output logic [NUM_SRC-1:0][VW-1:0] vec_q
);
  logic [NUM_SRC-1:0]         pend_d;
  logic [NUM_SRC-1:0][VW-1:0] vec_d;
  logic                       flag_en;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic take;
    assign take      = set_req[s] && !pend_q[s];
    assign pend_d[s] = clr[s] ? 1'b0 : (pend_q[s] | set_req[s]);
    assign vec_d[s]  = take ? msg_vector : vec_q[s];
  end

  assign flag_en = (|set_req) | (|clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vec_q  <= '0;
    end else if (flag_en) begin
      pend_q <= pend_d;
      vec_q  <= vec_d;
    end
  end

endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int GROUP     = 16,
  parameter int CLASS_LSB = 4,
  localparam int VW       = $clog2(NUM_VEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_valid,
  input  logic [VW-1:0] msg_vector,
  input  logic [2:0]    msg_mode,
  input  logic          msg_level,
  input  logic          int_enable,
  input  logic [VW-1:0] task_prio,
  input  logic          ack,
  output logic          int_pending,
  output logic [2:0]    ack_kind,
  output logic [VW-1:0] ack_vector,
  output logic          ack_level
);
  logic [NUM_VEC-1:0]         irr_q, tmr_q, isr_q;
  logic                       isr_any_q;
  logic [VW-1:0]              isr_top_q;
  logic [NUM_SRC-1:0]         spec_set, spec_clr, spec_pend;
  logic [NUM_SRC-1:0][VW-1:0] spec_vec;
  logic                       fix_valid;
  logic                       irr_any;
  logic [VW-1:0]              irr_hi;
  logic                       beats_isr, beats_tpr, fixed_ok, unmask_pend;
  logic                       serve;
  ack_kind_e                  kind;
  logic [VW-1:0]              sel_vec;

  // message decode
  always_comb begin
    fix_valid = 1'b0;
    spec_set  = '0;
    if (msg_valid) begin
      unique case (dmode_e'(msg_mode))
        DM_FIXED, DM_LOWEST: fix_valid = 1'b1;
        DM_SMI:              spec_set[SRC_SMI]  = 1'b1;
        DM_NMI:              spec_set[SRC_NMI]  = 1'b1;
        DM_INIT:             spec_set[SRC_INIT] = 1'b1;
        DM_EXTINT:           spec_set[SRC_EXT]  = 1'b1;
        default:             ;
      endcase
    end
  end

  irq_vec_store #(.NUM_VEC(NUM_VEC)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fix_valid  (fix_valid),
    .fix_vector (msg_vector),
    .fix_level  (msg_level),
    .serve      (serve),
    .serve_vec  (irr_hi),
    .irr_q      (irr_q),
    .tmr_q      (tmr_q),
    .isr_q      (isr_q),
    .isr_any_q  (isr_any_q),
    .isr_top_q  (isr_top_q)
  );

  irq_special_flags #(.VW(VW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_req    (spec_set),
    .msg_vector (msg_vector),
    .clr        (spec_clr),
    .pend_q     (spec_pend),
    .vec_q      (spec_vec)
  );

  irq_prio_enc #(.WIDTH(NUM_VEC), .GROUP(GROUP)) u_enc (
    .req (irr_q),
    .any (irr_any),
    .idx (irr_hi)
  );

  // offer logic
  assign beats_isr   = !isr_any_q || (irr_hi > isr_top_q);
  assign beats_tpr   = irr_hi[VW-1:CLASS_LSB] > task_prio[VW-1:CLASS_LSB];
  assign fixed_ok    = irr_any && beats_isr && beats_tpr;
  assign unmask_pend = spec_pend[SRC_SMI] | spec_pend[SRC_NMI] | spec_pend[SRC_INIT];
  assign int_pending = unmask_pend | (int_enable & (spec_pend[SRC_EXT] | fixed_ok));

  // acknowledge selection
  always_comb begin
    kind     = ACK_NONE;
    sel_vec  = '0;
    spec_clr = '0;
    serve    = 1'b0;
    if (ack && int_pending) begin
      if (spec_pend[SRC_SMI]) begin
        kind = ACK_SMI;  sel_vec = spec_vec[SRC_SMI];  spec_clr[SRC_SMI] = 1'b1;
      end else if (spec_pend[SRC_NMI]) begin
        kind = ACK_NMI;  sel_vec = spec_vec[SRC_NMI];  spec_clr[SRC_NMI] = 1'b1;
      end else if (spec_pend[SRC_INIT]) begin
        kind = ACK_INIT; sel_vec = spec_vec[SRC_INIT]; spec_clr[SRC_INIT] = 1'b1;
      end else if (spec_pend[SRC_EXT]) begin
        kind = ACK_EXT;  sel_vec = spec_vec[SRC_EXT];  spec_clr[SRC_EXT] = 1'b1;
      end else begin
        kind = ACK_FIXED; sel_vec = irr_hi; serve = 1'b1;
      end
    end
  end

  assign ack_kind   = kind;
  assign ack_vector = sel_vec;
  assign ack_level  = serve & tmr_q[irr_hi];

endmodule

// File: rtl/irq_accept_arb_chk.sv
module irq_accept_arb_chk #(
  parameter int NUM_VEC = 256,
  localparam int VW     = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic [VW-1:0]      msg_vector,
  input logic [2:0]         msg_mode,
  input logic               int_enable,
  input logic               ack,
  input logic               int_pending,
  input logic [2:0]         ack_kind,
  input logic [VW-1:0]      ack_vector,
  input logic [3:0]         spec_pend,
  input logic [NUM_VEC-1:0] irr,
  input logic [NUM_VEC-1:0] tmr,
  input logic [NUM_VEC-1:0] isr
);
  // R6
  unmask_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|spec_pend[2:0]) |-> int_pending);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_enable && !(|spec_pend[2:0])) |-> !int_pending);

  // R8
  smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && spec_pend[0]) |-> (ack_kind == 3'd1));

  // R8
  smi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_kind == 3'd1) |=> !spec_pend[0]);

  // R9
  fixed_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_kind == 3'd5) |=> (isr[$past(ack_vector)] && !irr[$past(ack_vector)]));

  // R3
  dup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_mode == 3'd0 || msg_mode == 3'd1) && irr[msg_vector])
      |=> (tmr[$past(msg_vector)] == $past(tmr[msg_vector])));

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack || !int_pending) |-> (ack_kind == 3'd0 && ack_vector == '0));

endmodule

bind irq_accept_arb irq_accept_arb_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_vector  (msg_vector),
  .msg_mode    (msg_mode),
  .int_enable  (int_enable),
  .ack         (ack),
  .int_pending (int_pending),
  .ack_kind    (ack_kind),
  .ack_vector  (ack_vector),
  .spec_pend   (spec_pend),
  .irr         (irr_q),
  .tmr         (tmr_q),
  .isr         (isr_q)
);

// File: tb/irq_accept_arb_test.sv
`timescale 1ns/1ps
module irq_accept_arb_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid;
  logic [7:0] msg_vector;
  logic [2:0] msg_mode;
  logic       msg_level;
  logic       int_enable;
  logic [7:0] task_prio;
  logic       ack;
  logic       int_pending;
  logic [2:0] ack_kind;
  logic [7:0] ack_vector;
  logic       ack_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_accept_arb uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_level(msg_level), .int_enable(int_enable),
    .task_prio(task_prio), .ack(ack), .int_pending(int_pending),
    .ack_kind(ack_kind), .ack_vector(ack_vector), .ack_level(ack_level)
  );

  // op: 0 message, 1 acknowledge, 2 idle (only enable / priority change)
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] vec;
    logic [2:0] mode;
    logic       lvl;
    logic       en;
    logic [7:0] tpr;
    logic       epend;
    logic [2:0] ekind;
    logic [7:0] evec;
    logic       elvl;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 29;
  localparam step_t TBL [NSTEP] = '{
    '{2'd0, 8'h45, 3'd0, 1'b1, 1'b1, 8'h00, 1'b1, 3'd0, 8'h00, 1'b0, 4'd2},  // R2 level fixed
    '{2'd0, 8'h45, 3'd0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd0, 8'h00, 1'b0, 4'd3},  // R3 duplicate edge
    '{2'd0, 8'h30, 3'd1, 1'b0, 1'b1, 8'h00, 1'b1, 3'd0, 8'h00, 1'b0, 4'd2},  // R2 lowest mode
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd5, 8'h45, 1'b1, 4'd9},  // R9 then 0x30 < ISR
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 4'd10}, // R10
    '{2'd0, 8'h80, 3'd0, 1'b0, 1'b1, 8'h80, 1'b0, 3'd0, 8'h00, 1'b0, 4'd7},  // R7 class equal
    '{2'd0, 8'hF0, 3'd6, 1'b0, 1'b1, 8'h80, 1'b0, 3'd0, 8'h00, 1'b0, 4'd5},  // R5 reserved 6
    '{2'd0, 8'hE0, 3'd3, 1'b0, 1'b1, 8'h80, 1'b0, 3'd0, 8'h00, 1'b0, 4'd5},  // R5 reserved 3
    '{2'd2, 8'h00, 3'd0, 1'b0, 1'b1, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd7},  // R7 class above
    '{2'd2, 8'h00, 3'd0, 1'b0, 1'b0, 8'h70, 1'b0, 3'd0, 8'h00, 1'b0, 4'd7},  // R7 masked
    '{2'd0, 8'h21, 3'd7, 1'b0, 1'b0, 8'h70, 1'b0, 3'd0, 8'h00, 1'b0, 4'd7},  // R7 ext masked
    '{2'd0, 8'h22, 3'd7, 1'b0, 1'b0, 8'h70, 1'b0, 3'd0, 8'h00, 1'b0, 4'd5},  // R5 ext duplicate
    '{2'd0, 8'h02, 3'd4, 1'b0, 1'b0, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd6},  // R6 NMI
    '{2'd0, 8'h03, 3'd5, 1'b0, 1'b0, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd6},  // R6 INIT
    '{2'd0, 8'h04, 3'd2, 1'b0, 1'b0, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd6},  // R6 SMI
    '{2'd0, 8'h09, 3'd2, 1'b0, 1'b0, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd4},  // R4 SMI duplicate
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h70, 1'b1, 3'd1, 8'h04, 1'b0, 4'd4},  // R4 first vector kept
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h70, 1'b1, 3'd2, 8'h02, 1'b0, 4'd8},  // R8 NMI next
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h70, 1'b0, 3'd3, 8'h03, 1'b0, 4'd8},  // R8 INIT next
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h70, 1'b0, 3'd0, 8'h00, 1'b0, 4'd10}, // R10 masked ack
    '{2'd2, 8'h00, 3'd0, 1'b0, 1'b1, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd7},  // R7 enable again
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h70, 1'b1, 3'd4, 8'h21, 1'b0, 4'd5},  // R5 ext first vector
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h70, 1'b0, 3'd5, 8'h80, 1'b0, 4'd9},  // R9 fixed 0x80
    '{2'd0, 8'h81, 3'd0, 1'b1, 1'b1, 8'h70, 1'b1, 3'd0, 8'h00, 1'b0, 4'd7},  // R7 above ISR
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h70, 1'b0, 3'd5, 8'h81, 1'b1, 4'd2},  // R2 level reported
    '{2'd0, 8'hFF, 3'd0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd0, 8'h00, 1'b0, 4'd2},  // R2 top vector
    '{2'd0, 8'h11, 3'd4, 1'b0, 1'b1, 8'h00, 1'b1, 3'd0, 8'h00, 1'b0, 4'd4},  // R4 NMI
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd2, 8'h11, 1'b0, 4'd8},  // R8 NMI over fixed
    '{2'd1, 8'h00, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd5, 8'hFF, 1'b0, 4'd9}   // R9 top vector
  };

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v, input logic [2:0] m, input logic l);
    @(negedge clk);
    msg_valid = 1'b1; msg_vector = v; msg_mode = m; msg_level = l;
    @(negedge clk);
    msg_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_ack(output logic [2:0] k, output logic [7:0] v, output logic l);
    @(negedge clk);
    ack = 1'b1;
    #1;
    k = ack_kind; v = ack_vector; l = ack_level;
    @(negedge clk);
    ack = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] k;
    logic [7:0] v;
    logic       l;
    rst_n = 1'b0; msg_valid = 1'b0; msg_vector = '0; msg_mode = '0;
    msg_level = 1'b0; int_enable = 1'b1; task_prio = '0; ack = 1'b0;
    do_reset();

    // R1 reset state
    check_val("R1 pending after reset", int_pending, 0);
    pulse_ack(k, v, l);
    check_val("R1 ack kind after reset", k, 0);
    check_val("R1 ack vector after reset", v, 0);

    // table walk
    for (int i = 0; i < NSTEP; i++) begin
      step_t s;
      s = TBL[i];
      @(negedge clk);
      int_enable = s.en;
      task_prio  = s.tpr;
      if (s.op == 2'd0) begin
        send(s.vec, s.mode, s.lvl);
      end else if (s.op == 2'd1) begin
        pulse_ack(k, v, l);
        check_val($sformatf("R%0d step %0d kind", s.req, i), k, s.ekind);
        check_val($sformatf("R%0d step %0d vector", s.req, i), v, s.evec);
        check_val($sformatf("R%0d step %0d level", s.req, i), l, s.elvl);
      end else begin
        #1;
      end
      check_val($sformatf("R%0d step %0d pending", s.req, i), int_pending, s.epend);
    end

    // R1 reset mid-run discards queued and special state
    send(8'hC0, 3'd0, 1'b1);
    send(8'h05, 3'd2, 1'b0);
    do_reset();
    int_enable = 1'b1; task_prio = '0;
    #1;
    check_val("R1 pending after mid-run reset", int_pending, 0);
    pulse_ack(k, v, l);
    check_val("R1 ack kind after mid-run reset", k, 0);

    // R7 vector 0 has class 0, never above task class 0
    send(8'h00, 3'd0, 1'b0);
    check_val("R7 vector zero gated", int_pending, 0);
    // R7 nothing in service ranks below every vector
    send(8'h10, 3'd0, 1'b1);
    check_val("R7 vector 0x10 offered", int_pending, 1);
    pulse_ack(k, v, l);
    check_val("R9 fixed kind 0x10", k, 5);
    check_val("R9 fixed vector 0x10", v, 8'h10);
    check_val("R2 level of 0x10", l, 1);
    check_val("R9 vector 0 below in-service", int_pending, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule